// File: doc/BRIEF.md
# IR carrier modulation generator

This block produces the carrier square wave for an infrared transmitter. The carrier frequency and duty cycle are set by two raw phase lengths, the high phase and the low phase. Both lengths are counted in ticks of a selectable timebase, and software writes them directly as one packed configuration word. Converting a frequency into counts is left to software.

Four timebases are available: the system clock itself, or one of three external enable pulses. These pulses come from a crystal divided by three, a 1 us tick and a 10 us tick. Each external pulse is one system cycle wide and is not a separate clock.

Besides the raw carrier, the block gives a one-cycle strobe on the final tick of each carrier period, which a downstream timebase can use. It also gives the IR drive output. This output follows the carrier while modulation is requested, and it can be forced high by a control input. While the enable input is low, the counters are held at their start point.

Top module: `ir_carrier_gen`

## Requirements
- R1: `tick_sel` selects the counting timebase: 0 = every system clock cycle, 1 = `tick_xtal3_i` pulses, 2 = `tick_1us_i` pulses, 3 = `tick_10us_i` pulses. The phase counters advance only on the selected tick, and pulses from unselected sources have no effect.
- R2: `mod_cfg` bits 15:0 hold (high phase length − 1) and bits 31:16 hold (low phase length − 1). Both lengths are in ticks.
- R3: Every carrier period begins with the high phase. `carrier_o` is 1 for exactly (high length) ticks and then 0 for exactly (low length) ticks, so one period spans high + low ticks.
- R4: While `en` is 0, `carrier_o` and `period_done_o` are 0 and the counters are held at the start of the high phase. In the first cycle with `en` at 1, `carrier_o` is 1. That first period uses the `mod_cfg` value present in the last disabled cycle.
- R5: A `mod_cfg` value written while enabled takes effect only at the next period boundary, so the period in progress is completed with its old lengths.
- R6: `period_done_o` is 1 for exactly one system cycle: the cycle in which the final tick of a period's low phase occurs. It is never 1 in two consecutive cycles.
- R7: With `force_high` at 0, `ir_o` equals `carrier_o` while `mod_req` is 1, and `ir_o` is 0 while `mod_req` is 0.
- R8: While `force_high` is 1, `ir_o` is 1, whatever the carrier and `mod_req` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global run enable; low holds counters at start |
| force_high | input | 1 | Forces `ir_o` high |
| mod_req | input | 1 | Gates the carrier onto `ir_o` |
| tick_sel | input | 2 | Timebase select (see R1) |
| tick_xtal3_i | input | 1 | One-cycle pulse from crystal/3 |
| tick_1us_i | input | 1 | One-cycle pulse every 1 us |
| tick_10us_i | input | 1 | One-cycle pulse every 10 us |
| mod_cfg | input | 32 | {low length − 1, high length − 1} |
| carrier_o | output | 1 | Raw carrier square wave |
| period_done_o | output | 1 | One-cycle strobe on a period's last tick |
| ir_o | output | 1 | Gated or forced IR drive output |

## Verification
The bench changes `mod_cfg` in the middle of a period. A design that reloads the lengths at once, instead of at the boundary, would cut the running phase short or stretch it, and the scoreboard would see the carrier edge in the wrong cycle. The bench also cycles the enable off and on partway through a period. A design that failed to clear its counters would resume in the low phase, where a fresh high phase is expected. With the minimum lengths of one tick each, the carrier toggles every cycle and the strobe appears every other cycle, which exposes any off-by-one in the stored minus-one counts. Each slow timebase runs while the other pulse inputs stay active, so a swapped select decode shows up as wrong phase lengths.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;

    typedef enum logic [1:0] {
        TICK_SYS   = 2'd0,
        TICK_XTAL3 = 2'd1,
        TICK_1US   = 2'd2,
        TICK_10US  = 2'd3
    } tick_src_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

endpackage

// File: rtl/ir_tick_mux.sv
module ir_tick_mux
    import ir_mod_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       pulse_xtal3,
    input  logic       pulse_1us,
    input  logic       pulse_10us,
    output logic       tick
);
    always_comb begin
        unique case (tick_src_e'(sel))
            TICK_SYS:   tick = 1'b1;
            TICK_XTAL3: tick = pulse_xtal3;
            TICK_1US:   tick = pulse_1us;
            TICK_10US:  tick = pulse_10us;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ir_cfg_hold.sv
module ir_cfg_hold #(
    parameter int CNT_W = 16,
    localparam int CFG_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CNT_W-1:0] hi_last,
    output logic [CNT_W-1:0] lo_last
);
    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.hi = cfg_in[CNT_W-1:0];
            cfg_d.lo = cfg_in[CFG_W-1:CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign hi_last = cfg_q.hi;
    assign lo_last = cfg_q.lo;
endmodule

// File: rtl/ir_phase_core.sv
module ir_phase_core
    import ir_mod_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_last,
    input  logic [CNT_W-1:0] lo_last,
    output phase_e           phase,
    output logic             wrap
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (!run) begin
            st_d.phase = PH_HIGH;
            st_d.cnt   = '0;
        end else if (tick) begin
            if (st_q.phase == PH_HIGH) begin
                if (st_q.cnt == hi_last) begin
                    st_d.phase = PH_LOW;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == lo_last) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = '0;
                    wrap       = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_HIGH;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_mod_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CFG_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             force_high,
    input  logic             mod_req,
    input  logic [1:0]       tick_sel,
    input  logic             tick_xtal3_i,
    input  logic             tick_1us_i,
    input  logic             tick_10us_i,
    input  logic [CFG_W-1:0] mod_cfg,
    output logic             carrier_o,
    output logic             period_done_o,
    output logic             ir_o
);
    logic             tick;
    logic             wrap;
    logic             cfg_load;
    logic [CNT_W-1:0] hi_last;
    logic [CNT_W-1:0] lo_last;
    phase_e           phase;

    ir_tick_mux u_tick (
        .sel         (tick_sel),
        .pulse_xtal3 (tick_xtal3_i),
        .pulse_1us   (tick_1us_i),
        .pulse_10us  (tick_10us_i),
        .tick        (tick)
    );

    // lengths follow the input while idle, and are resampled only at a wrap
    assign cfg_load = !en || wrap;

    ir_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .cfg_in  (mod_cfg),
        .hi_last (hi_last),
        .lo_last (lo_last)
    );

    ir_phase_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en),
        .tick    (tick),
        .hi_last (hi_last),
        .lo_last (lo_last),
        .phase   (phase),
        .wrap    (wrap)
    );

    assign carrier_o     = en && (phase == PH_HIGH);
    assign period_done_o = wrap;
    assign ir_o          = force_high || (mod_req && carrier_o);
endmodule

// File: rtl/ir_carrier_chk.sv
module ir_carrier_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic force_high,
    input logic mod_req,
    input logic carrier_o,
    input logic period_done_o,
    input logic ir_o
);
    assert_force_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_high |-> ir_o);

    assert_gate_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_high && mod_req) |-> (ir_o == carrier_o));

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_high && !mod_req) |-> !ir_o);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!carrier_o && !period_done_o));

    assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> carrier_o);

    assert_done_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_done_o |-> !carrier_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_done_o |=> !period_done_o);
endmodule

bind ir_carrier_gen ir_carrier_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .force_high    (force_high),
    .mod_req       (mod_req),
    .carrier_o     (carrier_o),
    .period_done_o (period_done_o),
    .ir_o          (ir_o)
);

// File: tb/sim_ir_carrier_gen.sv
`timescale 1ns/1ps
module sim_ir_carrier_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        force_high = 1'b0;
    logic        mod_req = 1'b0;
    logic [1:0]  tick_sel = 2'd0;
    logic        tx3 = 1'b0, t1 = 1'b0, t10 = 1'b0;
    logic [31:0] cfg = 32'd0;
    logic        carrier_o, period_done_o, ir_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // bench model of the requirements
    bit        m_low = 0;
    int        m_cnt = 0;
    int        m_hi = 0;
    int        m_lo = 0;

    typedef struct {
        logic  car;
        logic  done;
        logic  ir;
        string tag;
    } exp_t;
    exp_t sb[$];
    string cur_tag = "R4";

    always #2 clk = ~clk;

    ir_carrier_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .force_high(force_high),
        .mod_req(mod_req), .tick_sel(tick_sel), .tick_xtal3_i(tx3),
        .tick_1us_i(t1), .tick_10us_i(t10), .mod_cfg(cfg),
        .carrier_o(carrier_o), .period_done_o(period_done_o), .ir_o(ir_o)
    );

    function automatic bit sel_tick();
        case (tick_sel)
            2'd0: return 1'b1;
            2'd1: return tx3;
            2'd2: return t1;
            default: return t10;
        endcase
    endfunction

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // driver: one system cycle of stimulus plus its expected result
    task automatic step();
        exp_t e;
        tx3 = (cyc % 3) == 0;
        t1  = (cyc % 5) == 0;
        t10 = (cyc % 11) == 0;
        e.car  = en && !m_low;
        e.done = en && sel_tick() && m_low && (m_cnt == m_lo);
        e.ir   = force_high || (mod_req && e.car);
        e.tag  = cur_tag;
        sb.push_back(e);
        @(posedge clk);
        if (!en) begin
            m_low = 0; m_cnt = 0;
            m_hi = int'(cfg[15:0]); m_lo = int'(cfg[31:16]);
        end else if (sel_tick()) begin
            if (!m_low) begin
                if (m_cnt == m_hi) begin m_low = 1; m_cnt = 0; end
                else m_cnt++;
            end else if (m_cnt == m_lo) begin
                m_low = 0; m_cnt = 0;
                m_hi = int'(cfg[15:0]); m_lo = int'(cfg[31:16]);
            end else m_cnt++;
        end
        cyc++;
        #1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check1(e.tag, "carrier_o", carrier_o, e.car);
            check1(e.tag, "period_done_o", period_done_o, e.done);
            check1(e.tag, "ir_o", ir_o, e.ir);
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state (R4)
        cfg = {16'd4, 16'd2};
        #9;
        check1("R4", "reset carrier_o", carrier_o, 1'b0);
        check1("R4", "reset period_done_o", period_done_o, 1'b0);
        check1("R4", "reset ir_o", ir_o, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        cur_tag = "R4"; run(3);

        // R2 R3: high 3, low 5 on the system clock
        cur_tag = "R2 R3"; en = 1; mod_req = 1; run(40);

        // R5: change lengths mid period
        cur_tag = "R5"; run(2); cfg = {16'd0, 16'd1}; run(30);
        cfg = {16'd6, 16'd3}; run(5); cfg = {16'd2, 16'd0}; run(30);

        // R4: disable mid period, re-enable
        cur_tag = "R4"; run(3); en = 0; run(5);
        cfg = {16'd2, 16'd2}; en = 1; run(25);

        // R1: each slower timebase in turn
        cur_tag = "R1";
        for (int s = 1; s < 4; s++) begin
            en = 0; tick_sel = 2'(s); run(2);
            en = 1; run(120);
        end

        // R6: minimum lengths, strobe every other cycle
        cur_tag = "R6"; en = 0; tick_sel = 2'd0; cfg = 32'd0; run(2);
        en = 1; run(20);

        // R7: gate off, then back on
        cur_tag = "R7"; cfg = {16'd1, 16'd2}; mod_req = 0; run(15);
        mod_req = 1; run(10);

        // R8: forced high over carrier and gate
        cur_tag = "R8"; force_high = 1; run(10); mod_req = 0; run(10);
        en = 0; run(4);
        force_high = 0; cur_tag = "R7"; run(3);

        @(negedge clk); @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule